// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control part of a processor core that moves execution into an interrupt handler and back. When a request is accepted, it saves the interrupted program counter and then the status word on a downward-growing stack. It then acknowledges the winning source so that the source can clear its flag. It zeroes the status word, which turns off the global interrupt enable and leaves any low-power mode. Last, it fetches the handler address from a fixed slot near the top of the address space. A return command undoes the frame: it pops the status word first and the program counter second.

The core's register file stays outside the block. The block samples `pc_in`, `sr_in` and `sp_in` when it starts a sequence, and writes new values back through single-cycle load strobes. All memory traffic uses one word-wide valid/ready port. A request is presented on `mem_valid` with its address, direction and write data. These must stay unchanged until the responder raises `mem_ready`. The transfer takes place on the first rising edge where both are high, and read data is taken from `mem_rdata` on that same edge. The responder may hold `mem_ready` low for any number of cycles, and each such cycle lengthens the sequence by one.

Top module: `irq_entry_seq`

## Requirements
- R1: While idle, a maskable request on `irq_req` is taken only if bit 3 (`GIE_BIT`) of `sr_in` is 1. A non-maskable request on `nmi_req` is taken whatever that bit is.
- R2: `nmi_req` wins over every maskable line. Among maskable lines, the lowest set bit position wins.
- R3: The first transfer after acceptance writes the sampled `pc_in` to address `sp_in - 2`.
- R4: The second transfer writes the sampled `sr_in` to address `sp_in - 4`.
- R5: Next comes one cycle in which `ack_valid` is high and `ack_nmi`/`ack_idx` name the winner. In that cycle `sr_load` is high with `sr_out = 0`, and `sp_load` is high with `sp_out = sp_in - 4`.
- R6: The third transfer reads the vector word. Its address is 0xFFFC for the non-maskable source and 0xFFFA - 2*i for maskable line i. `pc_load` is high with `pc_out` equal to that word on the edge of the transfer.
- R7: `busy` is low out of reset. It is high from the cycle after acceptance through the cycle in which the final `pc_load` happens, and low after that. With zero wait states an entry keeps `busy` high for 4 cycles.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. Every responder wait cycle adds exactly one cycle to the sequence.
- R9: `reti_cmd` in the idle state reads the status word from `sp_in` and loads it through `sr_load`. It then reads the program counter from `sp_in + 2` and loads it through `pc_load`, with `sp_load` and `sp_out = sp_in + 4` in that same cycle.
- R10: If `reti_cmd` and a request arrive in the same idle cycle, the return runs first. The request is then judged against the restored status word.
- R11: `reti_cmd` has no effect while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Maskable request lines, held until acknowledged |
| nmi_req | input | 1 | Non-maskable request, held until acknowledged |
| reti_cmd | input | 1 | Return-from-handler command pulse |
| pc_in | input | AW | Current program counter |
| sr_in | input | AW | Current status word |
| sp_in | input | AW | Current stack pointer |
| pc_load | output | 1 | Load strobe for the program counter |
| pc_out | output | AW | New program counter value |
| sr_load | output | 1 | Load strobe for the status word |
| sr_out | output | AW | New status word value |
| sp_load | output | 1 | Load strobe for the stack pointer |
| sp_out | output | AW | New stack pointer value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, valid with `mem_ready` |
| ack_valid | output | 1 | Flag-clear strobe for the winning source |
| ack_nmi | output | 1 | Acknowledge is for the non-maskable source |
| ack_idx | output | IW | Maskable line being acknowledged |
| busy | output | 1 | A sequence is in progress |

## Verification
A return command and a pending request can both arrive in the same idle cycle. The bench stages this by building a stack frame whose saved status word has the enable bit set, while the live status word is zero. It then raises one request line together with `reti_cmd` on the same edge. The recorded transfer log must show both pops before any push. After that it must show a full entry for that line, with the request only now allowed by the restored enable bit.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_PC,
    ST_SAVE_SR,
    ST_CLEAR,
    ST_VECTOR,
    ST_REST_SR,
    ST_REST_PC
  } seq_state_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 8,
  parameter int IW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            nmi,
  input  logic            gie,
  output logic            take,
  output logic            take_nmi,
  output logic [IW-1:0]   idx
);
  logic any_req;

  always_comb begin
    any_req = 1'b0;
    idx     = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req = 1'b1;
        idx     = IW'(i);
      end
    end
  end

  assign take_nmi = nmi;
  assign take     = nmi | (gie & any_req);

  // R2: a maskable pick is a raised line with no raised line below it
  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_nmi) |-> (req[idx] && ((req & ((NSRC'(1) << idx) - NSRC'(1))) == '0)));

  // R1: a maskable pick needs the enable bit
  assert_gie_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nmi) |-> gie);
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int          AW      = 16,
  parameter int          IW      = 3,
  parameter logic [15:0] NMI_VEC = 16'hFFFC
) (
  input  logic          is_nmi,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] vec_addr
);
  localparam logic [AW-1:0] NMI_SLOT = AW'(NMI_VEC);

  always_comb begin
    if (is_nmi) vec_addr = NMI_SLOT;
    else        vec_addr = NMI_SLOT - AW'(2) - (AW'(idx) << 1);
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          NSRC    = 8,
  parameter int          GIE_BIT = 3,
  parameter logic [15:0] NMI_VEC = 16'hFFFC,
  localparam int         IW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nmi_req,
  input  logic            reti_cmd,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   sr_in,
  input  logic [AW-1:0]   sp_in,
  output logic            pc_load,
  output logic [AW-1:0]   pc_out,
  output logic            sr_load,
  output logic [AW-1:0]   sr_out,
  output logic            sp_load,
  output logic [AW-1:0]   sp_out,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  input  logic [AW-1:0]   mem_rdata,
  output logic            ack_valid,
  output logic            ack_nmi,
  output logic [IW-1:0]   ack_idx,
  output logic            busy
);
  localparam logic [AW-1:0] WORD = AW'(2);

  seq_state_t    state;
  logic [AW-1:0] pc_q, sr_q, sp_q;
  logic          src_nmi_q;
  logic [IW-1:0] src_idx_q;

  logic          take, take_nmi;
  logic [IW-1:0] pick_idx;
  logic [AW-1:0] vec_addr;
  logic          xfer;

  irq_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .nmi      (nmi_req),
    .gie      (sr_in[GIE_BIT]),
    .take     (take),
    .take_nmi (take_nmi),
    .idx      (pick_idx)
  );

  irq_vec_gen #(.AW(AW), .IW(IW), .NMI_VEC(NMI_VEC)) u_vec (
    .is_nmi   (src_nmi_q),
    .idx      (src_idx_q),
    .vec_addr (vec_addr)
  );

  assign xfer = mem_valid & mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pc_q      <= '0;
      sr_q      <= '0;
      sp_q      <= '0;
      src_nmi_q <= 1'b0;
      src_idx_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reti_cmd) begin
            sp_q  <= sp_in;
            state <= ST_REST_SR;
          end else if (take) begin
            pc_q      <= pc_in;
            sr_q      <= sr_in;
            sp_q      <= sp_in;
            src_nmi_q <= take_nmi;
            src_idx_q <= pick_idx;
            state     <= ST_SAVE_PC;
          end
        end
        ST_SAVE_PC: if (xfer) begin
          sp_q  <= sp_q - WORD;
          state <= ST_SAVE_SR;
        end
        ST_SAVE_SR: if (xfer) begin
          sp_q  <= sp_q - WORD;
          state <= ST_CLEAR;
        end
        ST_CLEAR:  state <= ST_VECTOR;
        ST_VECTOR: if (xfer) state <= ST_IDLE;
        ST_REST_SR: if (xfer) begin
          sp_q  <= sp_q + WORD;
          state <= ST_REST_PC;
        end
        ST_REST_PC: if (xfer) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_SAVE_PC: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - WORD;
        mem_wdata = pc_q;
      end
      ST_SAVE_SR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - WORD;
        mem_wdata = sr_q;
      end
      ST_VECTOR: begin
        mem_valid = 1'b1;
        mem_addr  = vec_addr;
      end
      ST_REST_SR, ST_REST_PC: begin
        mem_valid = 1'b1;
        mem_addr  = sp_q;
      end
      default: ;
    endcase
  end

  assign pc_load   = xfer && (state == ST_VECTOR || state == ST_REST_PC);
  assign pc_out    = mem_rdata;
  assign sr_load   = (state == ST_CLEAR) || (xfer && state == ST_REST_SR);
  assign sr_out    = (state == ST_CLEAR) ? '0 : mem_rdata;
  assign sp_load   = (state == ST_CLEAR) || (xfer && state == ST_REST_PC);
  assign sp_out    = (state == ST_CLEAR) ? sp_q : sp_q + WORD;
  assign ack_valid = (state == ST_CLEAR);
  assign ack_nmi   = src_nmi_q;
  assign ack_idx   = src_idx_q;
  assign busy      = (state != ST_IDLE);

  // R3: entry opens with a write of the sampled program counter below the stack top
  assert_save_pc_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(reti_cmd)) |->
      (mem_valid && mem_we && mem_wdata == $past(pc_in) && mem_addr == $past(sp_in) - WORD));

  // R9: a return opens with a read at the stack top
  assert_pop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(reti_cmd)) |-> (mem_valid && !mem_we && mem_addr == $past(sp_in)));

  // R6: the acknowledge cycle is followed by a vector read
  assert_vector_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (mem_valid && !mem_we && busy));

  // R8: a stalled request keeps its address, direction and data
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7: busy only drops after the cycle that loaded the program counter
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pc_load));

  // R5: acknowledge is a single-cycle pulse
  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int AW   = 16;
  localparam int NSRC = 8;
  localparam int IW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            nmi_req = 1'b0;
  logic            reti_cmd = 1'b0;
  logic [AW-1:0]   cpu_pc = 16'h1234, cpu_sr = 16'h0008, cpu_sp = 16'h0280;
  logic            pc_load, sr_load, sp_load;
  logic [AW-1:0]   pc_out, sr_out, sp_out;
  logic            mem_valid, mem_we;
  logic            mem_ready = 1'b0;
  logic [AW-1:0]   mem_addr, mem_wdata, mem_rdata;
  logic            ack_valid, ack_nmi;
  logic [IW-1:0]   ack_idx;
  logic            busy;

  always #2 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req), .reti_cmd(reti_cmd),
    .pc_in(cpu_pc), .sr_in(cpu_sr), .sp_in(cpu_sp),
    .pc_load(pc_load), .pc_out(pc_out), .sr_load(sr_load), .sr_out(sr_out),
    .sp_load(sp_load), .sp_out(sp_out),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ack_valid(ack_valid), .ack_nmi(ack_nmi), .ack_idx(ack_idx), .busy(busy)
  );

  logic [15:0] ram [0:127];
  assign mem_rdata = (mem_addr >= 16'hFF00) ? (16'hC000 | {8'h00, mem_addr[7:0]})
                                            : ram[mem_addr[7:1]];

  logic        lg_we   [0:15];
  logic [15:0] lg_addr [0:15];
  logic [15:0] lg_data [0:15];
  int lg_n = 0, busy_cyc = 0, ack_n = 0;
  logic last_nmi = 1'b0;
  logic [IW-1:0] last_idx = '0;
  int wait_n = 0, wcnt = 0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        if (lg_n < 16) begin
          lg_we[lg_n]   <= mem_we;
          lg_addr[lg_n] <= mem_addr;
          lg_data[lg_n] <= mem_we ? mem_wdata : mem_rdata;
        end
        lg_n <= lg_n + 1;
        if (mem_we) ram[mem_addr[7:1]] <= mem_wdata;
      end
      if (busy) busy_cyc <= busy_cyc + 1;
      if (ack_valid) begin
        ack_n    <= ack_n + 1;
        last_nmi <= ack_nmi;
        last_idx <= ack_idx;
        if (ack_nmi) nmi_req <= 1'b0;
        else irq_req[ack_idx] <= 1'b0;
      end
      if (pc_load) cpu_pc <= pc_out;
      if (sr_load) cpu_sr <= sr_out;
      if (sp_load) cpu_sp <= sp_out;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end
      if (mem_valid) begin
        if (wcnt >= wait_n) mem_ready = 1'b1;
        else wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    lg_n = 0; busy_cyc = 0; ack_n = 0;
  endtask

  task automatic set_cpu(input logic [15:0] pc, input logic [15:0] sr, input logic [15:0] sp);
    cpu_pc = pc; cpu_sr = sr; cpu_sp = sp;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic t_reset();
    cyc(1);
    chk(busy == 1'b0, "R7 busy after reset", busy, 0);
    chk(mem_valid == 1'b0 && ack_valid == 1'b0, "R8 idle bus after reset", mem_valid, 0);
  endtask

  task automatic t_entry_basic();
    set_cpu(16'h1234, 16'h0009, 16'h0280);
    clear_log();
    irq_req[2] = 1'b1;
    cyc(20);
    chk(lg_n == 3, "R3 transfer count", lg_n, 3);
    chk(lg_we[0] && lg_addr[0] == 16'h027E && lg_data[0] == 16'h1234, "R3 pc push", lg_addr[0], 16'h027E);
    chk(lg_we[1] && lg_addr[1] == 16'h027C && lg_data[1] == 16'h0009, "R4 sr push", lg_data[1], 16'h0009);
    chk(!lg_we[2] && lg_addr[2] == 16'hFFF6, "R6 vector addr line 2", lg_addr[2], 16'hFFF6);
    chk(ack_n == 1 && !last_nmi && last_idx == 3'd2, "R5 ack line 2", last_idx, 2);
    chk(cpu_sr == 16'h0000, "R5 sr cleared", cpu_sr, 0);
    chk(cpu_sp == 16'h027C, "R5 sp updated", cpu_sp, 16'h027C);
    chk(cpu_pc == 16'hC0F6, "R6 pc from vector", cpu_pc, 16'hC0F6);
    chk(busy_cyc == 4, "R7 busy length", busy_cyc, 4);
  endtask

  task automatic t_return();
    clear_log();
    reti_cmd = 1'b1;
    cyc(1);
    reti_cmd = 1'b0;
    cyc(15);
    chk(lg_n == 2 && !lg_we[0] && lg_addr[0] == 16'h027C, "R9 sr pop addr", lg_addr[0], 16'h027C);
    chk(!lg_we[1] && lg_addr[1] == 16'h027E, "R9 pc pop addr", lg_addr[1], 16'h027E);
    chk(cpu_sr == 16'h0009 && cpu_pc == 16'h1234, "R9 registers restored", cpu_pc, 16'h1234);
    chk(cpu_sp == 16'h0280, "R9 sp restored", cpu_sp, 16'h0280);
    chk(busy_cyc == 2, "R7 return busy length", busy_cyc, 2);
  endtask

  task automatic t_mask();
    set_cpu(16'h2000, 16'h00F7, 16'h0280);
    clear_log();
    irq_req[1] = 1'b1;
    cyc(20);
    chk(busy_cyc == 0 && lg_n == 0 && ack_n == 0, "R1 masked line ignored", lg_n, 0);
    nmi_req = 1'b1;
    cyc(20);
    chk(ack_n == 1 && last_nmi, "R1 nmi taken without enable", ack_n, 1);
    chk(lg_addr[2] == 16'hFFFC && cpu_pc == 16'hC0FC, "R6 nmi vector", lg_addr[2], 16'hFFFC);
    chk(lg_data[1] == 16'h00F7, "R4 sr pushed for nmi", lg_data[1], 16'h00F7);
    irq_req = '0;
    cyc(2);
  endtask

  task automatic t_priority();
    set_cpu(16'h3000, 16'h0008, 16'h0280);
    clear_log();
    irq_req = 8'b0010_1000;
    nmi_req = 1'b1;
    cyc(20);
    chk(ack_n == 1 && last_nmi, "R2 nmi beats maskable", last_nmi, 1);
    set_cpu(16'h3000, 16'h0008, 16'h0280);
    clear_log();
    cyc(20);
    chk(ack_n == 1 && !last_nmi && last_idx == 3'd3, "R2 line 3 beats line 5", last_idx, 3);
    set_cpu(16'h3000, 16'h0008, 16'h0280);
    clear_log();
    cyc(20);
    chk(ack_n == 1 && last_idx == 3'd5 && lg_addr[2] == 16'hFFF0, "R2 line 5 next", lg_addr[2], 16'hFFF0);
  endtask

  task automatic t_wait_states();
    set_cpu(16'h4000, 16'h0008, 16'h0280);
    clear_log();
    wait_n = 2;
    irq_req[0] = 1'b1;
    cyc(40);
    chk(busy_cyc == 10, "R8 stalls stretch entry", busy_cyc, 10);
    chk(lg_n == 3 && lg_addr[0] == 16'h027E && lg_addr[2] == 16'hFFFA, "R8 order kept under stalls", lg_addr[2], 16'hFFFA);
    chk(cpu_pc == 16'hC0FA, "R6 line 0 vector", cpu_pc, 16'hC0FA);
    wait_n = 0;
  endtask

  task automatic t_same_cycle();
    ram[7'h40] = 16'h0008;
    ram[7'h41] = 16'h4444;
    set_cpu(16'h5000, 16'h0000, 16'h0280);
    clear_log();
    irq_req[4] = 1'b1;
    reti_cmd   = 1'b1;
    cyc(1);
    reti_cmd = 1'b0;
    cyc(25);
    chk(lg_n == 5, "R10 transfer count", lg_n, 5);
    chk(!lg_we[0] && !lg_we[1] && lg_addr[0] == 16'h0280, "R10 return first", lg_addr[0], 16'h0280);
    chk(lg_we[2] && lg_addr[2] == 16'h0282 && lg_data[2] == 16'h4444, "R10 entry saves restored pc", lg_data[2], 16'h4444);
    chk(lg_we[3] && lg_data[3] == 16'h0008, "R10 entry saves restored sr", lg_data[3], 16'h0008);
    chk(ack_n == 1 && last_idx == 3'd4 && lg_addr[4] == 16'hFFF2, "R10 line 4 served", lg_addr[4], 16'hFFF2);
  endtask

  task automatic t_reti_busy();
    set_cpu(16'h6000, 16'h0008, 16'h0280);
    clear_log();
    irq_req[6] = 1'b1;
    cyc(1);
    reti_cmd = 1'b1;
    cyc(1);
    reti_cmd = 1'b0;
    cyc(20);
    chk(lg_n == 3 && busy_cyc == 4, "R11 return ignored while busy", lg_n, 3);
    chk(cpu_pc == 16'hC0EE && cpu_sp == 16'h027C, "R11 entry unaffected", cpu_pc, 16'hC0EE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_entry_basic();
    t_return();
    t_mask();
    t_priority();
    t_wait_states();
    t_same_cycle();
    t_reti_busy();
    finish_run();
  end
endmodule